// File: doc/BRIEF.md
# Configuration Override Table Loader

After reset this block walks a table of 64-bit records stored in a non-volatile memory. It fetches them one at a time through a word-read port. Each record whose leading code marks it as live is replayed as a single write into the configuration space of one of four functions. A select bit in the record chooses either the ordinary register or the mask register that sits beside it. A special code ends the table. A blank-device code also ends the scan quietly. Any other code is treated as a damaged table.

When the walk has ended, the block answers lookup requests. A lookup supplies a 12-bit register address and a function number. The answer says whether the table overrides that register and gives the 32-bit value. When several records match, the one written last in the table wins, which is the same result as replaying the writes in order.

The controller has three states:
- `ST_FETCH` holds the read request until the memory acknowledges it. It moves to `ST_READY` when the acknowledged record ends the scan.
- `ST_READY` accepts lookups. It moves to `ST_SEARCH` when a lookup arrives and at least one record is stored.
- `ST_SEARCH` steps backwards through the stored records. It returns to `ST_READY` on a hit or after the oldest record.

Top module: `cfg_override_loader`

## Requirements
- R1: A fetched 64-bit word is split as follows:
    - bits [63:48] hold the leading code;
    - bit [47] is unused;
    - bits [46:45] hold the function number;
    - bit [44] is the space select;
    - bits [43:32] hold the register address;
    - bits [31:0] hold the data.
- R1 (continued): A word whose leading code is 16'h9DA1 produces exactly one `wr_en` pulse. The pulse comes in the cycle after the acknowledge and carries that record's function, select and data.
- R2: The written address has the space select in bit 31, zeros in bits 30:12 and the record's register address in bits 11:0. `wr_mask_sel` equals the space select.
- R3: Leading code 16'h6A5D ends the scan with no write, and `error` stays 0.
- R4: Leading code 16'hFFFF ends the scan with no write, and `error` stays 0.
- R5: Any other leading code ends the scan with no write and sets `error`. `error` stays set until reset.
- R6: Records are requested at byte offsets 0, 8, 16, and so on. `ee_req` and `ee_addr` stay steady until `ee_ack` is seen.
- R7: If the record at index MAX_ENTRIES-1 is live, its write is applied. The scan then stops with `error` set.
- R8: `done` rises in the cycle after the acknowledge of the record that ends the scan. It stays high until reset, and no further reads are requested.
- R9: `lk_ready` is 0 while `done` is 0, so lookups are held off during the scan.
- R10: A lookup reports `lk_found`=1 with the stored data when a live record has the same function and address, whatever its space select. Otherwise it reports `lk_found`=0. Each answer is a one-cycle `lk_valid` pulse.
- R11: When several live records match a lookup, the data of the latest one in table order is returned.
- R12: The unused bit [47] has no effect on writes or lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; a new scan starts when it is released |
| ee_req | output | 1 | Read request to the table memory |
| ee_addr | output | $clog2(MAX_ENTRIES)+3 | Byte offset of the requested record |
| ee_ack | input | 1 | Read completed; `ee_rdata` is valid |
| ee_rdata | input | 64 | Record word |
| wr_en | output | 1 | Configuration write strobe |
| wr_func | output | 2 | Target function number |
| wr_mask_sel | output | 1 | 1 selects the mask register, 0 the ordinary register |
| wr_addr | output | 32 | Written address |
| wr_data | output | 32 | Written data |
| lk_req | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_addr | input | 12 | Register address to look up |
| lk_func | input | 2 | Function number to look up |
| lk_valid | output | 1 | Lookup answer strobe |
| lk_found | output | 1 | A matching record exists |
| lk_data | output | 32 | Data of the matching record |
| done | output | 1 | Scan finished |
| error | output | 1 | Scan ended on a damaged table or on the entry limit |

## Verification
The entry limit of R7 and the last-match rule of R11 are the hardest cases to reach from the ports. Reaching the limit needs a table with no terminator anywhere in range. Testing R11 needs repeated address and function pairs placed deep in the table. The bench builds the design with a small entry limit and draws addresses from a pool of four values, so duplicates and full tables both occur often. The memory model answers each read after a random delay, which exercises the hold rule of R6 throughout.

// File: rtl/cfgov_pkg.sv
package cfgov_pkg;

    localparam logic [15:0] CODE_LIVE  = 16'h9DA1;
    localparam logic [15:0] CODE_END   = 16'h6A5D;
    localparam logic [15:0] CODE_BLANK = 16'hFFFF;

    typedef enum logic [1:0] {
        K_APPLY,
        K_END,
        K_BLANK,
        K_BAD
    } rec_kind_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_READY,
        ST_SEARCH
    } ldr_state_e;

    typedef struct packed {
        logic [1:0]  func;
        logic        mask;
        logic [11:0] addr;
        logic [31:0] data;
    } ovr_rec_t;

endpackage

// File: rtl/cfgov_decode.sv
module cfgov_decode
    import cfgov_pkg::*;
(
    input  logic [63:0] word,
    output rec_kind_e   kind,
    output ovr_rec_t    rec
);
    logic [15:0] code;

    assign code     = word[63:48];
    assign rec.func = word[46:45];
    assign rec.mask = word[44];
    assign rec.addr = word[43:32];
    assign rec.data = word[31:0];

    always_comb begin
        if (code == CODE_LIVE) begin
            kind = K_APPLY;
        end else if (code == CODE_END) begin
            kind = K_END;
        end else if (code == CODE_BLANK) begin
            kind = K_BLANK;
        end else begin
            kind = K_BAD;
        end
    end
endmodule

// File: rtl/cfgov_store.sv
module cfgov_store
    import cfgov_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] w_idx,
    input  ovr_rec_t      w_rec,
    input  logic [IW-1:0] r_idx,
    input  logic [11:0]   key_addr,
    input  logic [1:0]    key_func,
    output logic          hit,
    output logic [31:0]   hit_data
);
    ovr_rec_t mem [DEPTH];
    ovr_rec_t cur;

    always_ff @(posedge clk) begin
        if (we) begin
            mem[w_idx] <= w_rec;
        end
    end

    assign cur      = mem[r_idx];
    assign hit      = (cur.addr == key_addr) && (cur.func == key_func);
    assign hit_data = cur.data;
endmodule

// File: rtl/cfg_override_loader.sv
module cfg_override_loader
    import cfgov_pkg::*;
#(
    parameter int MAX_ENTRIES = 256,
    localparam int IDX_W      = $clog2(MAX_ENTRIES),
    localparam int CNT_W      = $clog2(MAX_ENTRIES + 1),
    localparam int OFS_W      = IDX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             ee_req,
    output logic [OFS_W-1:0] ee_addr,
    input  logic             ee_ack,
    input  logic [63:0]      ee_rdata,
    output logic             wr_en,
    output logic [1:0]       wr_func,
    output logic             wr_mask_sel,
    output logic [31:0]      wr_addr,
    output logic [31:0]      wr_data,
    input  logic             lk_req,
    output logic             lk_ready,
    input  logic [11:0]      lk_addr,
    input  logic [1:0]       lk_func,
    output logic             lk_valid,
    output logic             lk_found,
    output logic [31:0]      lk_data,
    output logic             done,
    output logic             error
);
    ldr_state_e       state, state_nx;
    rec_kind_e        kind;
    ovr_rec_t         rec;
    logic [CNT_W-1:0] fill;
    logic [IDX_W-1:0] ptr;
    logic [11:0]      key_addr;
    logic [1:0]       key_func;
    logic             hit;
    logic [31:0]      hit_data;
    logic             at_limit;
    logic             take;
    logic             stop;

    cfgov_decode u_dec (
        .word (ee_rdata),
        .kind (kind),
        .rec  (rec)
    );

    cfgov_store #(.DEPTH(MAX_ENTRIES)) u_store (
        .clk      (clk),
        .we       (take && kind == K_APPLY),
        .w_idx    (fill[IDX_W-1:0]),
        .w_rec    (rec),
        .r_idx    (ptr),
        .key_addr (key_addr),
        .key_func (key_func),
        .hit      (hit),
        .hit_data (hit_data)
    );

    assign at_limit = (fill == CNT_W'(MAX_ENTRIES - 1));
    assign take     = (state == ST_FETCH) && ee_ack;
    assign stop     = take && (kind != K_APPLY || at_limit);
    assign ee_req   = (state == ST_FETCH);
    assign ee_addr  = {fill[IDX_W-1:0], 3'b000};
    assign lk_ready = (state == ST_READY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FETCH: begin
                if (stop) begin
                    state_nx = ST_READY;
                end
            end
            ST_READY: begin
                if (lk_req && fill != '0) begin
                    state_nx = ST_SEARCH;
                end
            end
            ST_SEARCH: begin
                if (hit || ptr == '0) begin
                    state_nx = ST_READY;
                end
            end
            default: state_nx = ST_FETCH;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill        <= '0;
            ptr         <= '0;
            key_addr    <= '0;
            key_func    <= '0;
            wr_en       <= 1'b0;
            wr_func     <= '0;
            wr_mask_sel <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            lk_valid    <= 1'b0;
            lk_found    <= 1'b0;
            lk_data     <= '0;
            done        <= 1'b0;
            error       <= 1'b0;
        end else begin
            wr_en    <= 1'b0;
            lk_valid <= 1'b0;
            unique case (state)
                ST_FETCH: begin
                    if (take && kind == K_APPLY) begin
                        wr_en       <= 1'b1;
                        wr_func     <= rec.func;
                        wr_mask_sel <= rec.mask;
                        wr_addr     <= {rec.mask, 19'd0, rec.addr};
                        wr_data     <= rec.data;
                        fill        <= fill + 1'b1;
                    end
                    if (stop) begin
                        done  <= 1'b1;
                        error <= (kind == K_BAD) || (kind == K_APPLY);
                    end
                end
                ST_READY: begin
                    if (lk_req) begin
                        key_addr <= lk_addr;
                        key_func <= lk_func;
                        if (fill == '0) begin
                            lk_valid <= 1'b1;
                            lk_found <= 1'b0;
                            lk_data  <= '0;
                        end else begin
                            ptr <= IDX_W'(fill - 1'b1);
                        end
                    end
                end
                ST_SEARCH: begin
                    if (hit) begin
                        lk_valid <= 1'b1;
                        lk_found <= 1'b1;
                        lk_data  <= hit_data;
                    end else if (ptr == '0) begin
                        lk_valid <= 1'b1;
                        lk_found <= 1'b0;
                        lk_data  <= '0;
                    end else begin
                        ptr <= ptr - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfgov_checker.sv
module cfgov_checker #(
    parameter int MAX_ENTRIES = 256,
    localparam int OFS_W      = $clog2(MAX_ENTRIES) + 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ee_req,
    input logic [OFS_W-1:0] ee_addr,
    input logic             ee_ack,
    input logic             wr_en,
    input logic             wr_mask_sel,
    input logic [31:0]      wr_addr,
    input logic             lk_ready,
    input logic             lk_valid,
    input logic             done,
    input logic             error
);
    p_addr_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr[30:12] == 19'd0 && wr_addr[31] == wr_mask_sel));

    p_write_after_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ee_ack));

    p_error_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> done);

    p_error_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_req && !ee_ack) |=> (ee_req && $stable(ee_addr)));

    p_offset_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ee_ack |=> (!ee_req || ee_addr == $past(ee_addr) + OFS_W'(8)));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    p_no_fetch_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ee_req);

    p_ready_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_ready |-> done);

    p_answer_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> !lk_valid);
endmodule

bind cfg_override_loader cfgov_checker #(.MAX_ENTRIES(MAX_ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ee_req      (ee_req),
    .ee_addr     (ee_addr),
    .ee_ack      (ee_ack),
    .wr_en       (wr_en),
    .wr_mask_sel (wr_mask_sel),
    .wr_addr     (wr_addr),
    .lk_ready    (lk_ready),
    .lk_valid    (lk_valid),
    .done        (done),
    .error       (error)
);

// File: tb/cfg_override_loader_tb_top.sv
`timescale 1ns/1ps
module cfg_override_loader_tb_top;
    localparam int MAXE  = 8;
    localparam int OFS_W = $clog2(MAXE) + 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ee_req;
    logic [OFS_W-1:0] ee_addr;
    logic             ee_ack = 1'b0;
    logic [63:0]      ee_rdata = '0;
    logic             wr_en;
    logic [1:0]       wr_func;
    logic             wr_mask_sel;
    logic [31:0]      wr_addr;
    logic [31:0]      wr_data;
    logic             lk_req = 1'b0;
    logic             lk_ready;
    logic [11:0]      lk_addr = '0;
    logic [1:0]       lk_func = '0;
    logic             lk_valid;
    logic             lk_found;
    logic [31:0]      lk_data;
    logic             done;
    logic             error;

    logic [63:0] rom [MAXE];
    int          rd_i = 0;
    int          lat = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 0;

    always #4 clk = ~clk;

    cfg_override_loader #(.MAX_ENTRIES(MAXE)) dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [15:0] code, input logic rsv, input logic [1:0] f,
                                       input logic m, input logic [11:0] a, input logic [31:0] d);
        return {code, rsv, f, m, a, d};
    endfunction

    function automatic bit ref_error();
        for (int i = 0; i < MAXE; i++) begin
            logic [15:0] c;
            c = rom[i][63:48];
            if (c == 16'h9DA1) begin
                if (i == MAXE - 1) return 1'b1;
            end else begin
                return !(c == 16'h6A5D || c == 16'hFFFF);
            end
        end
        return 1'b0;
    endfunction

    task automatic ref_lookup(input logic [11:0] a, input logic [1:0] f, output bit fnd, output logic [31:0] d);
        fnd = 0;
        d = '0;
        for (int i = 0; i < MAXE; i++) begin
            if (rom[i][63:48] != 16'h9DA1) break;
            if (rom[i][43:32] == a && rom[i][46:45] == f) begin
                fnd = 1;
                d = rom[i][31:0];
            end
        end
    endtask

    // memory model and per-record checks
    always @(negedge clk) begin
        if (!rst_n) begin
            ee_ack = 1'b0;
            lat = 0;
        end else if (ee_ack) begin
            logic [63:0] e;
            bit live, term;
            e = ee_rdata;
            live = (e[63:48] == 16'h9DA1);
            term = !live || (rd_i == MAXE - 1);
            check(wr_en == live, "R1 R3 R4 R5 write strobe", 64'(wr_en), 64'(live));
            if (live) begin
                check(wr_func == e[46:45] && wr_data == e[31:0], "R1 R12 write fields",
                      {30'd0, wr_func, wr_data}, {30'd0, e[46:45], e[31:0]});
                check(wr_addr == {e[44], 19'd0, e[43:32]} && wr_mask_sel == e[44], "R2 write address",
                      {31'd0, wr_mask_sel, wr_addr}, {31'd0, e[44], e[44], 19'd0, e[43:32]});
            end
            check(done == term, "R8 done timing", 64'(done), 64'(term));
            rd_i++;
            ee_ack = 1'b0;
            lat = $urandom_range(0, 2);
        end else begin
            if (wr_en) check(1'b0, "R1 stray write", 64'(wr_en), 64'd0);
            if (!done) check(lk_ready == 1'b0, "R9 ready during scan", 64'(lk_ready), 64'd0);
            if (done && ee_req) check(1'b0, "R8 request after done", 64'(ee_req), 64'd0);
            if (ee_req) begin
                if (lat == 0) begin
                    check(ee_addr == OFS_W'(rd_i * 8), "R6 offset", 64'(ee_addr), 64'(rd_i * 8));
                    ee_rdata = rom[ee_addr[OFS_W-1:3]];
                    ee_ack = 1'b1;
                end else begin
                    lat--;
                end
            end
        end
    end

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic run_table();
        int w;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!done && !error && !wr_en && !lk_ready && !lk_valid, "R8 reset state",
              {59'd0, done, error, wr_en, lk_ready, lk_valid}, 64'd0);
        rd_i = 0;
        rst_n = 1'b1;
        w = 0;
        while (!done && w < 500) begin
            @(negedge clk);
            w++;
        end
        check(done, "R8 scan finished", 64'(done), 64'd1);
        repeat (3) @(negedge clk);
        check(error == ref_error(), "R3 R4 R5 R7 error flag", 64'(error), 64'(ref_error()));
        check(!ee_req, "R8 idle after done", 64'(ee_req), 64'd0);
    endtask

    task automatic lookup(input logic [11:0] a, input logic [1:0] f, input string tag);
        bit fnd;
        logic [31:0] d;
        int w;
        ref_lookup(a, f, fnd, d);
        while (!lk_ready) @(negedge clk);
        lk_addr = a;
        lk_func = f;
        lk_req = 1'b1;
        @(negedge clk);
        lk_req = 1'b0;
        w = 0;
        while (!lk_valid && w < 100) begin
            @(negedge clk);
            w++;
        end
        check(lk_valid, {tag, " answer strobe"}, 64'(lk_valid), 64'd1);
        check(lk_found == fnd, {tag, " found"}, 64'(lk_found), 64'(fnd));
        if (fnd) check(lk_data == d, {tag, " data"}, 64'(lk_data), 64'(d));
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // directed: duplicates, mask select, unused bit set
        rom[0] = mk(16'h9DA1, 1'b0, 2'd0, 1'b0, 12'h010, 32'h1111_0000);
        rom[1] = mk(16'h9DA1, 1'b0, 2'd1, 1'b1, 12'hFFF, 32'h2222_0000);
        rom[2] = mk(16'h9DA1, 1'b1, 2'd3, 1'b0, 12'h010, 32'h3333_0000);
        rom[3] = mk(16'h9DA1, 1'b0, 2'd0, 1'b1, 12'h010, 32'h4444_0000);
        rom[4] = mk(16'h6A5D, 1'b0, 2'd0, 1'b0, 12'h000, 32'h0);
        rom[5] = mk(16'h9DA1, 1'b0, 2'd2, 1'b0, 12'h123, 32'h5555_0000);
        rom[6] = '1;
        rom[7] = '1;
        run_table();
        lookup(12'h010, 2'd0, "R11 last match");
        lookup(12'hFFF, 2'd1, "R10 mask record");
        lookup(12'h123, 2'd2, "R3 beyond end");
        lookup(12'h010, 2'd3, "R12 unused bit");
        lookup(12'h010, 2'd2, "R10 wrong func");
        // blank device
        for (int i = 0; i < MAXE; i++) rom[i] = '1;
        run_table();
        lookup(12'h010, 2'd0, "R4 blank");
        // damaged code after two records
        rom[0] = mk(16'h9DA1, 1'b0, 2'd2, 1'b0, 12'h020, 32'hCAFE_0001);
        rom[1] = mk(16'h9DA1, 1'b0, 2'd2, 1'b0, 12'h030, 32'hCAFE_0002);
        rom[2] = mk(16'h1234, 1'b0, 2'd2, 1'b0, 12'h040, 32'hCAFE_0003);
        run_table();
        lookup(12'h030, 2'd2, "R5 before damage");
        lookup(12'h040, 2'd2, "R5 damaged record");
        // entry limit reached
        for (int i = 0; i < MAXE; i++)
            rom[i] = mk(16'h9DA1, 1'b0, 2'd1, 1'b0, 12'(i), 32'hA000_0000 + 32'(i));
        run_table();
        lookup(12'(MAXE - 1), 2'd1, "R7 last slot");
        lookup(12'h000, 2'd1, "R7 first slot");
        // random tables
        for (int t = 0; t < 24; t++) begin
            int len;
            logic [11:0] pool [4];
            pool[0] = 12'h010; pool[1] = 12'h020; pool[2] = 12'h7FF; pool[3] = 12'hABC;
            len = $urandom_range(0, MAXE + 1);
            for (int i = 0; i < MAXE; i++) begin
                if (i < len) begin
                    rom[i] = mk(16'h9DA1, 1'($urandom), 2'($urandom), 1'($urandom),
                                pool[$urandom_range(0, 3)], $urandom);
                end else if (i == len) begin
                    case ($urandom_range(0, 2))
                        0: rom[i] = {16'h6A5D, 48'($urandom)};
                        1: rom[i] = {16'hFFFF, 48'($urandom)};
                        default: rom[i] = {16'h0F00 | 16'($urandom_range(0, 255)), 48'($urandom)};
                    endcase
                end else begin
                    rom[i] = {32'($urandom), 32'($urandom)};
                end
            end
            run_table();
            for (int k = 0; k < 4; k++)
                lookup(pool[$urandom_range(0, 3)], 2'($urandom), "R10 R11 random");
        end
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        finish_up();
    end
endmodule